// File: doc/BRIEF.md
# Partial Delay-and-Sum Beamformer

This block takes one sample from each of 32 receive channels per valid cycle, delays each channel by its own whole number of sample periods, and adds the delayed samples into one partial beam value. The per-channel delays cover both steering and focusing. They also correct for differences in signal path length between channels. A central controller supplies the delays. The result is deliberately left unscaled, because a later stage adds several such partial values from other channel groups to form the finished beam.

Delays are written one channel at a time into a staging set while a firing is in progress. The staging set is copied into the working set by a single-cycle firing start pulse, and that pulse also restarts the per-firing sample index. A channel whose delay has not yet elapsed since the start pulse adds zero. Each channel keeps its history in a ring of 256 entries. All rings share one write pointer. A registered binary adder tree produces the sum.

Top module: `pdas_beamformer`

## Requirements
- R1: A write (`cfg_we` high) stores `cfg_dly` as the staged delay of channel `cfg_ch`. Staged values do not change the output until the next `fire_start`.
- R2: On a cycle with `fire_start` high, the staged delays of all channels become the working delays. A staging write made in that same cycle is not part of the committed set and takes effect only at the following `fire_start`.
- R3: Channel c occupies bits [c*12 +: 12] of `in_samples` as a signed two's-complement value. For the k-th valid sample after a firing start (k = 0 is the first), channel c adds its own sample from valid sample k - d, where d is its working delay. Delay is counted in valid samples, not clock cycles.
- R4: While k < d for a channel, that channel adds zero to the sum.
- R5: `out_sum` is the plain signed sum of the 32 channel terms on 17 bits, with no scaling or saturation. All channels at -2048 give -65536, and all at +2047 give +65504.
- R6: `out_valid` is high exactly 6 clock cycles after each cycle with `in_valid` high, and `out_sum` carries that sample's result in the same cycle. Idle cycles between samples do not change results. `out_sum` holds its value while `out_valid` is low.
- R7: After reset, `out_valid` and `out_sum` are 0 and all working and staged delays are 0. Samples given before the first firing start therefore pass undelayed.
- R8: When `fire_start` and `in_valid` are high in the same cycle, that sample is index k = 0 under the newly committed delays.
- R9: The largest delay, 255, is exact. Such a channel first adds a nonzero term at k = 255, and from then on it adds its own sample from 255 valid samples earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A new sample set is present on `in_samples` |
| in_samples | input | 384 | 32 signed 12-bit samples, channel c at bits [c*12 +: 12] |
| fire_start | input | 1 | Single-cycle firing start: commit staged delays and restart the sample index |
| cfg_we | input | 1 | Write strobe for a staged delay |
| cfg_ch | input | 5 | Channel selected by the staging write |
| cfg_dly | input | 8 | Delay value in sample periods, 0 to 255 |
| out_valid | output | 1 | `out_sum` carries a new partial sum |
| out_sum | output | 17 | Signed, unscaled partial beam sum |

## Verification
The assertions assume that `fire_start` is a single-cycle pulse and that `in_valid` is low while reset is active. The valid-latency check depends on the latter, because it compares against a history that starts at zero at reset. The bench drives every control input for exactly one cycle, with changes made at the falling clock edge. It keeps `in_valid` low until reset has been released for several cycles. It uses only channel indices inside the 32-channel range, so each staging write lands on an existing register and the write-landing check always has a defined target.

// File: rtl/pdas_pkg.sv
`timescale 1ns/1ps
package pdas_pkg;
  localparam int unsigned PDAS_CHANNELS    = 32;
  localparam int unsigned PDAS_SAMPLE_BITS = 12;
  localparam int unsigned PDAS_DELAY_BITS  = 8;

  // growth of one bit per tree level keeps the full sum exact
  function automatic int unsigned pdas_sum_width(int unsigned nch, int unsigned sw);
    return sw + $clog2(nch);
  endfunction
endpackage

// File: rtl/pdas_coef_bank.sv
`timescale 1ns/1ps
module pdas_coef_bank #(
  parameter int unsigned NUM_CH  = 32,
  parameter int unsigned DELAY_W = 8,
  parameter int unsigned CH_W    = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [CH_W-1:0]           cfg_ch,
  input  logic [DELAY_W-1:0]        cfg_dly,
  input  logic                      commit,
  output logic [NUM_CH*DELAY_W-1:0] shadow_flat,
  output logic [NUM_CH*DELAY_W-1:0] active_flat
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic               wr_hit;
    logic [DELAY_W-1:0] shadow_q;
    logic [DELAY_W-1:0] active_q;

    assign wr_hit = cfg_we && (cfg_ch == CH_W'(c));

    // staging register: written by the configuration port only
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_q <= '0;
      end else if (wr_hit) begin
        shadow_q <= cfg_dly;
      end
    end

    // working register: copied from staging on the firing pulse
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        active_q <= '0;
      end else if (commit) begin
        active_q <= shadow_q;
      end
    end

    assign shadow_flat[c*DELAY_W +: DELAY_W] = shadow_q;
    assign active_flat[c*DELAY_W +: DELAY_W] = active_q;
  end
endmodule

// File: rtl/pdas_delay_lane.sv
`timescale 1ns/1ps
module pdas_delay_lane #(
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned DELAY_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [DELAY_W-1:0]  wr_ptr,
  input  logic [DELAY_W-1:0]  dly,
  input  logic [DELAY_W-1:0]  idx,
  input  logic [SAMPLE_W-1:0] din,
  output logic [SAMPLE_W-1:0] dout
);
  localparam int unsigned DEPTH = 1 << DELAY_W;

  logic [SAMPLE_W-1:0] ring [DEPTH];
  logic [DELAY_W-1:0]  rd_addr;
  logic [SAMPLE_W-1:0] tap;
  logic [SAMPLE_W-1:0] dout_d;

  // history store, no reset needed: unwritten slots are never selected
  always_ff @(posedge clk) begin
    if (en) begin
      ring[wr_ptr] <= din;
    end
  end

  always_comb begin
    rd_addr = wr_ptr - dly;
    tap     = (dly == '0) ? din : ring[rd_addr];
    dout_d  = (idx >= dly) ? tap : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
    end else if (en) begin
      dout <= dout_d;
    end
  end
endmodule

// File: rtl/pdas_adder_tree.sv
`timescale 1ns/1ps
module pdas_adder_tree #(
  parameter int unsigned NUM_IN = 32,
  parameter int unsigned IN_W   = 12,
  parameter int unsigned OUT_W  = 17
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_vld,
  input  logic [NUM_IN*IN_W-1:0] in_flat,
  output logic                   out_vld,
  output logic [OUT_W-1:0]       out_sum
);
  localparam int unsigned LVLS = $clog2(NUM_IN);

  logic [LVLS:0] vld;
  assign vld[0] = in_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld[LVLS:1] <= '0;
    end else begin
      vld[LVLS:1] <= vld[LVLS-1:0];
    end
  end

  for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
    localparam int unsigned NODES = NUM_IN >> l;
    logic [NODES*OUT_W-1:0] s;

    if (l == 0) begin : g_leaf
      for (genvar i = 0; i < NODES; i++) begin : g_ext
        assign s[i*OUT_W +: OUT_W] = OUT_W'($signed(in_flat[i*IN_W +: IN_W]));
      end
    end else begin : g_add
      logic [NODES*OUT_W-1:0] s_d;
      for (genvar i = 0; i < NODES; i++) begin : g_pair
        assign s_d[i*OUT_W +: OUT_W] = g_lvl[l-1].s[(2*i)*OUT_W +: OUT_W]
                                     + g_lvl[l-1].s[(2*i+1)*OUT_W +: OUT_W];
      end
      // level register advances only when its stage carries a sample
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s <= '0;
        end else if (vld[l-1]) begin
          s <= s_d;
        end
      end
    end
  end

  assign out_sum = g_lvl[LVLS].s;
  assign out_vld = vld[LVLS];
endmodule

// File: rtl/pdas_beamformer.sv
`timescale 1ns/1ps
module pdas_beamformer
  import pdas_pkg::*;
#(
  parameter int unsigned NUM_CH   = PDAS_CHANNELS,
  parameter int unsigned SAMPLE_W = PDAS_SAMPLE_BITS,
  parameter int unsigned DELAY_W  = PDAS_DELAY_BITS
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 in_valid,
  input  logic [NUM_CH*SAMPLE_W-1:0]           in_samples,
  input  logic                                 fire_start,
  input  logic                                 cfg_we,
  input  logic [$clog2(NUM_CH)-1:0]            cfg_ch,
  input  logic [DELAY_W-1:0]                   cfg_dly,
  output logic                                 out_valid,
  output logic [SAMPLE_W+$clog2(NUM_CH)-1:0]   out_sum
);
  localparam int unsigned CH_W  = $clog2(NUM_CH);
  localparam int unsigned LVLS  = $clog2(NUM_CH);
  localparam int unsigned SUM_W = pdas_sum_width(NUM_CH, SAMPLE_W);
  localparam logic [DELAY_W-1:0] IDX_SAT = '1;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q;
  logic rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // shared ring pointer and per-firing sample index
  logic [DELAY_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [DELAY_W-1:0] idx_q, idx_d, idx_cur;

  always_comb begin
    idx_cur  = fire_start ? '0 : idx_q;
    wr_ptr_d = wr_ptr_q;
    idx_d    = idx_cur;
    if (in_valid) begin
      wr_ptr_d = wr_ptr_q + DELAY_W'(1);
      if (idx_cur != IDX_SAT) begin
        idx_d = idx_cur + DELAY_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wr_ptr_q <= '0;
      idx_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      idx_q    <= idx_d;
    end
  end

  // delay coefficients
  logic [NUM_CH*DELAY_W-1:0] dly_shadow_flat;
  logic [NUM_CH*DELAY_W-1:0] dly_active_flat;

  pdas_coef_bank #(
    .NUM_CH (NUM_CH),
    .DELAY_W(DELAY_W),
    .CH_W   (CH_W)
  ) u_coef (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cfg_we     (cfg_we),
    .cfg_ch     (cfg_ch),
    .cfg_dly    (cfg_dly),
    .commit     (fire_start),
    .shadow_flat(dly_shadow_flat),
    .active_flat(dly_active_flat)
  );

  // per-channel delay stage
  logic [NUM_CH*SAMPLE_W-1:0] lane_flat;
  logic                       lane_vld_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    logic [DELAY_W-1:0] dly_eff;
    // a committing sample already uses the set being committed
    assign dly_eff = fire_start ? dly_shadow_flat[c*DELAY_W +: DELAY_W]
                                : dly_active_flat[c*DELAY_W +: DELAY_W];

    pdas_delay_lane #(
      .SAMPLE_W(SAMPLE_W),
      .DELAY_W (DELAY_W)
    ) u_lane (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .en    (in_valid),
      .wr_ptr(wr_ptr_q),
      .dly   (dly_eff),
      .idx   (idx_cur),
      .din   (in_samples[c*SAMPLE_W +: SAMPLE_W]),
      .dout  (lane_flat[c*SAMPLE_W +: SAMPLE_W])
    );
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      lane_vld_q <= 1'b0;
    end else begin
      lane_vld_q <= in_valid;
    end
  end

  // summation
  pdas_adder_tree #(
    .NUM_IN(NUM_CH),
    .IN_W  (SAMPLE_W),
    .OUT_W (SUM_W)
  ) u_tree (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .in_vld (lane_vld_q),
    .in_flat(lane_flat),
    .out_vld(out_valid),
    .out_sum(out_sum)
  );
endmodule

// File: rtl/pdas_checker.sv
`timescale 1ns/1ps
module pdas_checker #(
  parameter int unsigned NUM_CH   = 32,
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned DELAY_W  = 8,
  parameter int unsigned SUM_W    = 17,
  parameter int unsigned LAT      = 6
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic                      fire_start,
  input logic                      cfg_we,
  input logic [$clog2(NUM_CH)-1:0] cfg_ch,
  input logic [DELAY_W-1:0]        cfg_dly,
  input logic [NUM_CH*DELAY_W-1:0] shadow_flat,
  input logic [NUM_CH*DELAY_W-1:0] active_flat,
  input logic                      out_valid,
  input logic [SUM_W-1:0]          out_sum
);
  localparam int SUM_MIN = -(int'(NUM_CH) * (2 ** (SAMPLE_W - 1)));
  localparam int SUM_MAX = int'(NUM_CH) * (2 ** (SAMPLE_W - 1) - 1);

  logic [LAT-1:0]            hist;
  logic                      wr_seen_q;
  logic [$clog2(NUM_CH)-1:0] wr_ch_q;
  logic [DELAY_W-1:0]        wr_dly_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist      <= '0;
      wr_seen_q <= 1'b0;
      wr_ch_q   <= '0;
      wr_dly_q  <= '0;
    end else begin
      hist      <= {hist[LAT-2:0], in_valid};
      wr_seen_q <= cfg_we;
      wr_ch_q   <= cfg_ch;
      wr_dly_q  <= cfg_dly;
    end
  end

  assert_shadow_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_seen_q |-> shadow_flat[int'(wr_ch_q)*DELAY_W +: DELAY_W] == wr_dly_q);

  assert_shadow_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(shadow_flat));

  assert_commit_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire_start |=> active_flat == $past(shadow_flat));

  assert_active_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_start |=> $stable(active_flat));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'($signed(out_sum)) >= SUM_MIN && int'($signed(out_sum)) <= SUM_MAX));

  assert_valid_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == hist[LAT-1]);

  assert_sum_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_sum));
endmodule

bind pdas_beamformer pdas_checker #(
  .NUM_CH  (NUM_CH),
  .SAMPLE_W(SAMPLE_W),
  .DELAY_W (DELAY_W),
  .SUM_W   (SUM_W),
  .LAT     (LVLS + 1)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .in_valid   (in_valid),
  .fire_start (fire_start),
  .cfg_we     (cfg_we),
  .cfg_ch     (cfg_ch),
  .cfg_dly    (cfg_dly),
  .shadow_flat(dly_shadow_flat),
  .active_flat(dly_active_flat),
  .out_valid  (out_valid),
  .out_sum    (out_sum)
);

// File: tb/pdas_beamformer_test.sv
`timescale 1ns/1ps
module pdas_beamformer_test;
  localparam int NCH = 32;
  localparam int SW  = 12;

  logic           clk;
  logic           rst_n;
  logic           in_valid;
  logic [NCH*SW-1:0] in_samples;
  logic           fire_start;
  logic           cfg_we;
  logic [4:0]     cfg_ch;
  logic [7:0]     cfg_dly;
  logic           out_valid;
  logic [16:0]    out_sum;

  pdas_beamformer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_samples(in_samples),
    .fire_start(fire_start), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_dly(cfg_dly),
    .out_valid(out_valid), .out_sum(out_sum)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  bit    done   = 1'b0;
  string cur_req = "R7";
  int    sh  [NCH];
  int    act [NCH];
  int    kb = 0;
  int    exp_q   [$];
  int    stamp_q [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, actual, expected, cyc);
    end
  endtask

  function automatic int smp(input int seed, input int mode, input int k, input int c);
    if (mode == 1) return -2048;
    if (mode == 2) return 2047;
    return ((k * 37 + c * 113 + seed * 211) % 4096) - 2048;
  endfunction

  function automatic int model_sum(input int seed, input int mode, input int k);
    int s = 0;
    for (int c = 0; c < NCH; c++) begin
      if (k >= act[c]) s += smp(seed, mode, k - act[c], c);
    end
    return s;
  endfunction

  // output monitor: each result must match the model and arrive 6 cycles after its input
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected out_valid", 1, 0);
      end else begin
        int e;
        int st;
        e  = exp_q.pop_front();
        st = stamp_q.pop_front();
        chk(int'($signed(out_sum)) == e, cur_req, int'($signed(out_sum)), e);
        chk(cyc == st, "R6 latency", cyc, st);
      end
    end
  end

  task automatic push_sample(input int seed, input int mode, input bit fire,
                             input bit wr, input int wch, input int wd);
    if (fire) begin
      for (int c = 0; c < NCH; c++) act[c] = sh[c];
      kb = 0;
    end
    if (wr) sh[wch] = wd;
    for (int c = 0; c < NCH; c++) in_samples[c*SW +: SW] = SW'(smp(seed, mode, kb, c));
    in_valid   = 1'b1;
    fire_start = fire;
    cfg_we     = wr;
    cfg_ch     = 5'(wch);
    cfg_dly    = 8'(wd);
    exp_q.push_back(model_sum(seed, mode, kb));
    stamp_q.push_back(cyc + 6);
    kb++;
    @(negedge clk);
    in_valid   = 1'b0;
    fire_start = 1'b0;
    cfg_we     = 1'b0;
  endtask

  task automatic cfg_write(input int ch, input int d);
    cfg_we  = 1'b1;
    cfg_ch  = 5'(ch);
    cfg_dly = 8'(d);
    sh[ch]  = d;
    @(negedge clk);
    cfg_we  = 1'b0;
  endtask

  task automatic drain(input string req);
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  // R7: reset state, then undelayed pass-through before any firing
  task automatic t_reset_pass();
    cur_req = "R7";
    chk(out_valid == 1'b0, "R7 out_valid after reset", int'(out_valid), 0);
    chk(out_sum == '0, "R7 out_sum after reset", int'($signed(out_sum)), 0);
    for (int i = 0; i < 5; i++) push_sample(1, 0, 1'b0, 1'b0, 0, 0);
    drain("R7 drain");
  endtask

  // R1: staged writes leave the output unchanged until a firing start
  task automatic t_shadow_only();
    for (int c = 0; c < NCH; c++) cfg_write(c, c + 1);
    cur_req = "R1";
    for (int i = 0; i < 6; i++) begin
      push_sample(1, 0, 1'b0, 1'b0, 0, 0);
      @(negedge clk);
    end
    drain("R1 drain");
  endtask

  // R3 R4 R8 R6: staggered delays, firing on the first sample, idle gaps
  task automatic t_commit_stagger();
    cfg_write(0, 0);
    cur_req = "R3 R4 R8";
    for (int i = 0; i < 40; i++) begin
      push_sample(2, 0, i == 0, 1'b0, 0, 0);
      if (i % 3 == 2) repeat (2) @(negedge clk);
    end
    drain("R6 drain");
  endtask

  // R2: a write in the firing cycle is left out of the committed set
  task automatic t_same_cycle_write();
    cur_req = "R2 same-cycle";
    push_sample(4, 0, 1'b1, 1'b1, 5, 0);
    for (int i = 1; i < 12; i++) push_sample(4, 0, 1'b0, 1'b0, 0, 0);
    cur_req = "R2 next firing";
    for (int i = 0; i < 12; i++) push_sample(5, 0, i == 0, 1'b0, 0, 0);
    drain("R2 drain");
  endtask

  // R5: unscaled extremes
  task automatic t_extremes();
    for (int c = 0; c < NCH; c++) cfg_write(c, 0);
    cur_req = "R5 minimum";
    for (int i = 0; i < 4; i++) push_sample(6, 1, i == 0, 1'b0, 0, 0);
    cur_req = "R5 maximum";
    for (int i = 0; i < 4; i++) push_sample(6, 2, 1'b0, 1'b0, 0, 0);
    drain("R5 drain");
  endtask

  // R9: largest delays
  task automatic t_max_delay();
    cfg_write(7, 255);
    cfg_write(20, 254);
    cur_req = "R9";
    for (int i = 0; i < 262; i++) push_sample(3, 0, i == 0, 1'b0, 0, 0);
    drain("R9 drain");
  endtask

  initial begin
    rst_n      = 1'b0;
    in_valid   = 1'b0;
    in_samples = '0;
    fire_start = 1'b0;
    cfg_we     = 1'b0;
    cfg_ch     = '0;
    cfg_dly    = '0;
    for (int c = 0; c < NCH; c++) begin
      sh[c]  = 0;
      act[c] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_pass();
    t_shadow_only();
    t_commit_stagger();
    t_same_cycle_write();
    t_extremes();
    t_max_delay();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule